// File: doc/BRIEF.md
# Sequenced Four-Slot Edge Timestamp Unit

This block timestamps transitions on one asynchronous event line. A free-running timer supplies the time base, and a two-bit sequence pointer chooses which of four capture registers takes the next timestamp. Each of the four slots has its own edge direction. A transition is accepted only when its direction matches the direction programmed for the slot that the pointer currently selects. When a transition is accepted, the timer value is stored in that slot, the pointer moves to the next slot, and a one-cycle event pulse reports the index of the slot that was written.

The pointer is a four-state machine with the states ST_SLOT0, ST_SLOT1, ST_SLOT2 and ST_SLOT3. Its transitions are:
- ADVANCE: an accepted edge moves the pointer from ST_SLOTn to ST_SLOT(n+1), and ST_SLOT3 goes to ST_SLOT0.
- HOLD: with no accepted edge, the pointer stays in its state.
- RESTART: a clear command forces the pointer to ST_SLOT0 from any state.

Software uses a small synchronous register port. Through it, software programs the per-slot directions, starts and stops the timer, restarts the timer and pointer, and reads the timer, the pointer and the four timestamps.

Top module: `seq_edge_capture`

## Requirements
- R1: After reset, the following are all zero: the timer, the pointer, the four captures, the enable bit and the direction bits. evt_valid is low.
- R2: While the enable bit is 1, the timer increases by one every clock. While the enable bit is 0, the timer holds its value.
- R3: ev_in passes through two synchronizing flops before edge detection. The stored timestamp is the timer value present in the cycle where the synchronized edge is detected, which is the timer value just after the second rising clock edge that follows the change on ev_in.
- R4: A detected edge is accepted when its direction matches direction bit n of the slot n that the pointer selects (0 = rising, 1 = falling). On acceptance, capture n takes the timer value and the pointer advances by one.
- R5: An edge whose direction does not match the selected slot's direction bit is ignored. The pointer and all captures keep their values, and no event pulse is raised.
- R6: The pointer wraps from 3 to 0, so the fifth accepted edge overwrites capture 0.
- R7: While the enable bit is 0, edges are dropped. No capture, pointer change or event pulse occurs.
- R8: Writing CTRL with bit 1 set zeroes the timer and the pointer in that cycle and leaves the captures unchanged. In that cycle the clear takes priority over a coincident capture.
- R9: evt_valid is a one-cycle pulse in the cycle after an edge is accepted. In that cycle evt_slot holds the index of the slot that was written, and that capture register already holds its new value.
- R10: Register map (word addresses on reg_addr). Address 0 is CTRL: bit 0 is enable; bit 1 is clear, which always reads 0. Address 1 holds the direction bits in bits [3:0]. Address 2 is the timer and address 3 is the pointer in bits [1:0]. Addresses 4 to 7 are captures 0 to 3. Read data is registered, with one cycle of latency. Writes to addresses 2 to 7 are ignored. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_in | input | 1 | Asynchronous event line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | AW (4) | Register word address |
| reg_wdata | input | TW (32) | Register write data |
| reg_rdata | output | TW (32) | Registered read data for reg_addr |
| evt_valid | output | 1 | One-cycle capture event pulse |
| evt_slot | output | 2 | Index of the slot just written |

## Verification
The bench sweeps all sixteen direction patterns and drives alternating rising and falling edges for each. Every accept, reject and pointer position is therefore checked against an arithmetic model. A design that decodes the direction bit inverted, or reads it from the wrong slot, shows up as missing or extra event pulses and as a wrong pointer readback. A design that samples the timer one stage early or late in the synchronizer stores timestamps off by one. A design that fails to wrap the pointer writes the wrong slot on the fifth capture. The bench also covers the following, each checked at the register port:
- edges while the timer is stopped;
- writes to read-only addresses;
- a clear that must keep the stored timestamps.

// File: rtl/cap_pkg.sv
package cap_pkg;
    localparam int NSLOT = 4;
    localparam int SW    = $clog2(NSLOT);

    typedef enum logic [SW-1:0] {
        ST_SLOT0 = 2'd0,
        ST_SLOT1 = 2'd1,
        ST_SLOT2 = 2'd2,
        ST_SLOT3 = 2'd3
    } slot_st_t;

    localparam int ADR_CTRL  = 0;
    localparam int ADR_POL   = 1;
    localparam int ADR_TIMER = 2;
    localparam int ADR_PTR   = 3;
    localparam int ADR_CAP0  = 4;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_CLR_BIT = 1;
endpackage

// File: rtl/cap_sync_edge.sv
module cap_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    always_comb begin
        rise = chain_q[STAGES-1] & ~last_q;
        fall = ~chain_q[STAGES-1] & last_q;
    end

    // R3: a detected rising edge cannot repeat on the next cycle
    p_rise_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    p_fall_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/cap_sequencer.sv
module cap_sequencer
    import cap_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear,
    input  logic             rise,
    input  logic             fall,
    input  logic [NSLOT-1:0] pol,
    output logic [SW-1:0]    slot,
    output logic             cap_we,
    output logic             evt_valid,
    output logic [SW-1:0]    evt_slot
);
    slot_st_t state_q, state_d;
    logic     edge_ok;

    always_comb begin
        edge_ok = pol[state_q] ? fall : rise;
        cap_we  = enable & ~clear & edge_ok;
        slot    = state_q;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLOT0: state_d = cap_we ? ST_SLOT1 : ST_SLOT0;
            ST_SLOT1: state_d = cap_we ? ST_SLOT2 : ST_SLOT1;
            ST_SLOT2: state_d = cap_we ? ST_SLOT3 : ST_SLOT2;
            ST_SLOT3: state_d = cap_we ? ST_SLOT0 : ST_SLOT3;
            default:  state_d = ST_SLOT0;
        endcase
        if (clear) state_d = ST_SLOT0;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SLOT0;
        else        state_q <= state_d;
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_valid <= 1'b0;
            evt_slot  <= '0;
        end else begin
            evt_valid <= cap_we;
            evt_slot  <= state_q;
        end
    end

    p_ptr_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_we |=> (SW'(state_q) == SW'($past(SW'(state_q)) + 1'b1)));
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_we && !clear) |=> $stable(state_q));
    p_clear_ptr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (state_q == ST_SLOT0));
    p_evt_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> $past(enable));
endmodule

// File: rtl/cap_regfile.sv
module cap_regfile
    import cap_pkg::*;
#(
    parameter int TW = 32,
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [TW-1:0]    reg_wdata,
    input  logic             cap_we,
    input  logic [SW-1:0]    cap_slot,
    input  logic [SW-1:0]    ptr,
    output logic             enable,
    output logic             clear,
    output logic [NSLOT-1:0] pol,
    output logic [TW-1:0]    reg_rdata
);
    logic [TW-1:0] timer_q;
    logic [TW-1:0] cap_q [NSLOT];
    logic [TW-1:0] rd_mux;
    logic [AW-1:0] cap_off;
    logic          wr_ctrl;
    logic          wr_pol;

    always_comb begin
        wr_ctrl = reg_we && (reg_addr == AW'(ADR_CTRL));
        wr_pol  = reg_we && (reg_addr == AW'(ADR_POL));
        clear   = wr_ctrl && reg_wdata[CTRL_CLR_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable <= 1'b0;
            pol    <= '0;
        end else begin
            if (wr_ctrl) enable <= reg_wdata[CTRL_EN_BIT];
            if (wr_pol)  pol    <= reg_wdata[NSLOT-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      timer_q <= '0;
        else if (clear)  timer_q <= '0;
        else if (enable) timer_q <= timer_q + 1'b1;
    end

    generate
        for (genvar i = 0; i < NSLOT; i++) begin : g_cap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cap_q[i] <= '0;
                else if (cap_we && (cap_slot == SW'(i))) cap_q[i] <= timer_q;
            end

            p_cap_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !(cap_we && (cap_slot == SW'(i))) |=> $stable(cap_q[i]));
        end
    endgenerate

    always_comb begin
        cap_off = reg_addr - AW'(ADR_CAP0);
        rd_mux  = '0;
        if (reg_addr == AW'(ADR_CTRL)) begin
            rd_mux[CTRL_EN_BIT] = enable;
        end else if (reg_addr == AW'(ADR_POL)) begin
            rd_mux[NSLOT-1:0] = pol;
        end else if (reg_addr == AW'(ADR_TIMER)) begin
            rd_mux = timer_q;
        end else if (reg_addr == AW'(ADR_PTR)) begin
            rd_mux[SW-1:0] = ptr;
        end else if ((reg_addr >= AW'(ADR_CAP0)) && (cap_off < AW'(NSLOT))) begin
            rd_mux = cap_q[cap_off[SW-1:0]];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) reg_rdata <= '0;
        else        reg_rdata <= rd_mux;
    end

    p_timer_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !clear) |=> (timer_q == $past(timer_q) + 1'b1));
    p_timer_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> $stable(timer_q));
    p_clear_timer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (timer_q == '0));
endmodule

// File: rtl/seq_edge_capture.sv
module seq_edge_capture
    import cap_pkg::*;
#(
    parameter int TW          = 32,
    parameter int AW          = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_in,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [TW-1:0] reg_wdata,
    output logic [TW-1:0] reg_rdata,
    output logic          evt_valid,
    output logic [1:0]    evt_slot
);
    logic             rise, fall;
    logic             enable, clear, cap_we;
    logic [NSLOT-1:0] pol;
    logic [SW-1:0]    slot;
    logic [SW-1:0]    evt_slot_w;

    cap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ev_in),
        .rise     (rise),
        .fall     (fall)
    );

    cap_sequencer u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .clear     (clear),
        .rise      (rise),
        .fall      (fall),
        .pol       (pol),
        .slot      (slot),
        .cap_we    (cap_we),
        .evt_valid (evt_valid),
        .evt_slot  (evt_slot_w)
    );

    cap_regfile #(.TW(TW), .AW(AW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .cap_we    (cap_we),
        .cap_slot  (slot),
        .ptr       (slot),
        .enable    (enable),
        .clear     (clear),
        .pol       (pol),
        .reg_rdata (reg_rdata)
    );

    assign evt_slot = evt_slot_w;

    // R9: the reported slot is the one the pointer selected when the edge was taken
    p_evt_slot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_slot == $past(slot)));
endmodule

// File: tb/tb_seq_edge_capture.sv
`timescale 1ns/1ps
module tb_seq_edge_capture;
    localparam int TW = 32;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ev_in = 1'b0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [TW-1:0] reg_wdata = '0;
    logic [TW-1:0] reg_rdata;
    logic          evt_valid;
    logic [1:0]    evt_slot;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [TW-1:0] m_tim;
    logic          m_en;
    logic [1:0]    m_ptr = 2'd0;
    logic [3:0]    m_pol = 4'd0;
    logic [TW-1:0] m_cap [4];

    always #5 clk = ~clk;

    seq_edge_capture #(.TW(TW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .evt_valid(evt_valid), .evt_slot(evt_slot)
    );

    // timer model derived from R2, R8
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tim <= '0;
            m_en  <= 1'b0;
        end else if (reg_we && reg_addr == 4'd0) begin
            m_en <= reg_wdata[0];
            if (reg_wdata[1]) m_tim <= '0;
            else if (m_en)    m_tim <= m_tim + 1;
        end else if (m_en) begin
            m_tim <= m_tim + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [TW-1:0] act,
                       input logic [TW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [TW-1:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 4'd0 && d[1]) m_ptr = 2'd0;
        if (a == 4'd1) m_pol = d[3:0];
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [TW-1:0] v,
                      output logic [TW-1:0] tim_then);
        @(negedge clk);
        reg_addr = a;
        tim_then = m_tim;
        @(posedge clk);
        #1 v = reg_rdata;
    endtask

    task automatic do_edge();
        logic rising, take;
        logic [TW-1:0] exp_t, v, tt;
        @(negedge clk);
        ev_in = ~ev_in;
        rising = ev_in;
        @(posedge clk);
        @(posedge clk);
        #1;
        exp_t = m_tim;
        take = m_en && (m_pol[m_ptr] == !rising);
        @(posedge clk);
        #1;
        // R4 / R5 / R7: pulse only on a matching, enabled edge
        chk(evt_valid == take, "R4/R5/R7 evt_valid", TW'(evt_valid), TW'(take));
        if (take) begin
            chk(evt_slot == m_ptr, "R9 evt_slot", TW'(evt_slot), TW'(m_ptr));
            m_cap[m_ptr] = exp_t;
            m_ptr = m_ptr + 1;
        end
        @(posedge clk);
        #1;
        chk(evt_valid == 1'b0, "R9 one-cycle pulse", TW'(evt_valid), 0);
        rd(4'd3, v, tt);
        chk(v == TW'(m_ptr), "R4/R5/R6 pointer", v, TW'(m_ptr));
        for (int s = 0; s < 4; s++) begin
            rd(AW'(4 + s), v, tt);
            chk(v == m_cap[s], "R3/R4 capture value", v, m_cap[s]);
        end
    endtask

    initial begin
        logic [TW-1:0] v, v2, t1, t2, c0_first;
        for (int s = 0; s < 4; s++) m_cap[s] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        #1 chk(evt_valid == 1'b0, "R1 evt_valid", TW'(evt_valid), 0);
        for (int a = 0; a < 8; a++) begin
            rd(AW'(a), v, t1);
            chk(v == '0, "R1 reset register", v, 0);
        end

        // R2: counting and holding
        wr(4'd0, 32'h1);
        rd(4'd2, v, t1);
        rd(4'd2, v2, t2);
        chk(v == t1, "R2 timer matches model", v, t1);
        chk(v2 == v + 1, "R2 timer increments", v2, v + 1);
        wr(4'd0, 32'h0);
        rd(4'd2, v, t1);
        repeat (5) @(posedge clk);
        rd(4'd2, v2, t2);
        chk(v2 == v, "R2 timer holds", v2, v);

        // R10: CTRL clear bit reads 0, read-only writes ignored, unmapped reads 0
        wr(4'd0, 32'h3);
        rd(4'd0, v, t1);
        chk(v == 32'h1, "R10 ctrl readback", v, 1);
        wr(4'd0, 32'h0);
        rd(4'd2, v, t1);
        wr(4'd2, 32'hDEAD_BEEF);
        wr(4'd5, 32'h1234_5678);
        rd(4'd2, v2, t2);
        chk(v2 == v, "R10 timer write ignored", v2, v);
        rd(4'd5, v2, t2);
        chk(v2 == m_cap[1], "R10 capture write ignored", v2, m_cap[1]);
        rd(4'd9, v, t1);
        chk(v == '0, "R10 unmapped read", v, 0);
        wr(4'd1, 32'hFFFF_FFF5);
        rd(4'd1, v, t1);
        chk(v == 32'h5, "R10 direction readback", v, 5);

        // R7: edges dropped while stopped
        for (int k = 0; k < 3; k++) do_edge();

        // sweep of all direction patterns, R3 R4 R5 R6
        for (int p = 0; p < 16; p++) begin
            wr(4'd1, TW'(p));
            wr(4'd0, 32'h3);
            for (int k = 0; k < 9; k++) do_edge();
        end

        // R6: explicit wrap, fifth capture overwrites slot 0
        wr(4'd0, 32'h0);
        if (ev_in) do_edge();
        wr(4'd1, 32'hA);
        wr(4'd0, 32'h3);
        do_edge();
        c0_first = m_cap[0];
        for (int k = 0; k < 4; k++) do_edge();
        rd(4'd3, v, t1);
        chk(v == 32'd1, "R6 pointer after five captures", v, 1);
        rd(4'd4, v, t1);
        chk(v == m_cap[0] && v != c0_first, "R6 slot 0 overwritten", v, m_cap[0]);

        // R8: clear zeroes timer and pointer, keeps captures
        wr(4'd0, 32'h3);
        wr(4'd0, 32'h2);
        rd(4'd2, v, t1);
        chk(v == '0, "R8 timer cleared", v, 0);
        rd(4'd3, v, t1);
        chk(v == '0, "R8 pointer cleared", v, 0);
        for (int s = 0; s < 4; s++) begin
            rd(AW'(4 + s), v, t1);
            chk(v == m_cap[s], "R8 captures kept", v, m_cap[s]);
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule